// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a single burst request into the sequence of column addresses that an SDRAM controller puts on the address pins for each data beat. A one-cycle start pulse captures a start column, a read/write flag and a mode-register image. From the next cycle on, the block emits one column per clock with a valid flag. A last flag marks the final beat. The burst ends when its programmed length is reached or when a terminate input arrives. The mode image selects the burst length (1, 2, 4, 8 or a whole 256-column page), sequential or interleaved ordering, a read latency of 2 or 3 cycles, and a single-location write option.

The block also follows the read data. It raises a data-valid strobe in the cycle each read beat appears on the data bus, counted from the cycle in which the read was issued. It also drives a bus output enable that a read mask can suppress. The mask takes effect two cycles after the cycle in which it is raised.

Top module: `sdram_burst_colgen`

## Requirements
- R1: Mode bits [2:0] give the burst length: 000=1, 001=2, 010=4, 011=8, 111=full page. After a start pulse is sampled, the first beat appears in the next cycle with col_addr equal to the start column and col_valid high, and exactly that many beats follow.
- R2: When mode bit 3 is 0 (sequential), the column counts upward and wraps within the aligned block of burst-length size. For BL=8 and low bits 5, the low bits run 5,6,7,0,1,2,3,4 and the upper bits do not change.
- R3: When mode bit 3 is 1 (interleaved), beat i carries the start column XOR i. For BL=8 and low bits 5, the low bits run 5,4,7,6,1,0,3,2.
- R4: In full-page mode the column increments modulo 256, rolls from 255 to 0, keeps going until terminated, and never asserts col_last.
- R5: col_last is high together with the final beat of a 1/2/4/8 burst. col_valid is low in the cycle after that beat.
- R6: When terminate is high in a cycle with no start, col_valid is low in the next cycle.
- R7: A start pulse during an active burst drops the current burst. The new burst's first beat appears in the next cycle.
- R8: Mode bit 9 set makes a write burst one beat long with col_last. Reads still use the programmed length.
- R9: Mode bits [6:4] give the read latency: 010=2, 011=3. For a read whose start is sampled at the end of cycle 0, rd_data_valid is high in cycles CL through CL+BL-1 and low otherwise. rd_data_valid stays low for writes.
- R10: When rd_mask is high in cycle k, dq_oe is low in cycle k+2. Otherwise dq_oe follows rd_data_valid.
- R11: A start sampled while the burst-length or latency field holds a reserved code sets config_error. config_error stays set until reset, and from then on no burst starts.
- R12: During and right after reset, col_valid, col_last, rd_data_valid, dq_oe and config_error are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle burst request |
| is_write | input | 1 | Burst direction captured with start: 1 write, 0 read |
| start_col | input | 8 | First column of the burst |
| mode_word | input | 12 | Mode-register image captured with start |
| terminate | input | 1 | Ends the active burst after the current beat |
| rd_mask | input | 1 | Read mask; disables the bus two cycles later |
| col_addr | output | 8 | Column address of the current beat |
| col_valid | output | 1 | A beat is presented this cycle |
| col_last | output | 1 | Current beat is the final one |
| rd_data_valid | output | 1 | Read data is on the bus this cycle |
| dq_oe | output | 1 | Data bus output enable |
| config_error | output | 1 | Sticky reserved-code flag |

## Verification
The properties assume that start is a single-cycle pulse and that a new read does not begin while data from an earlier read with a different latency is still in flight. Under that assumption the data-valid tap always matches the beat that produced it. The properties also assume that rd_mask has a defined level from the first cycle after reset. The directed stimulus issues each request with a one-cycle start and holds rd_mask low except where a test masks a beat on purpose. It lets every read drain before the next read begins. The one deliberate overlap, the restart test, reuses the same latency.

// File: rtl/sbcg_pkg.sv
`timescale 1ns/1ps
package sbcg_pkg;

    typedef enum logic [2:0] {
        BLEN_1    = 3'b000,
        BLEN_2    = 3'b001,
        BLEN_4    = 3'b010,
        BLEN_8    = 3'b011,
        BLEN_PAGE = 3'b111
    } blen_e;

    typedef struct packed {
        blen_e blen;
        logic  ilv;
        logic  lat3;
        logic  wr_single;
        logic  bad;
    } mode_cfg_t;

endpackage

// File: rtl/sbcg_mode_decode.sv
`timescale 1ns/1ps
module sbcg_mode_decode
    import sbcg_pkg::*;
#(
    parameter int MODE_W = 12
) (
    input  logic [MODE_W-1:0] mode_word,
    output mode_cfg_t         cfg
);
    localparam int BL_LSB = 0;
    localparam int BT_BIT = 3;
    localparam int CL_LSB = 4;
    localparam int WM_BIT = 9;

    logic [2:0] bl_code;
    logic [2:0] cl_code;
    logic       unused_mode;

    assign bl_code     = mode_word[BL_LSB +: 3];
    assign cl_code     = mode_word[CL_LSB +: 3];
    assign unused_mode = ^{mode_word[MODE_W-1:WM_BIT+1], mode_word[WM_BIT-1:CL_LSB+3]};

    always_comb begin
        cfg           = '0;
        cfg.ilv       = mode_word[BT_BIT];
        cfg.wr_single = mode_word[WM_BIT];
        case (bl_code)
            3'b000, 3'b001, 3'b010, 3'b011, 3'b111: cfg.blen = blen_e'(bl_code);
            default: begin
                cfg.blen = BLEN_1;
                cfg.bad  = 1'b1;
            end
        endcase
        case (cl_code)
            3'b010:  cfg.lat3 = 1'b0;
            3'b011:  cfg.lat3 = 1'b1;
            default: cfg.bad  = 1'b1;
        endcase
    end

endmodule

// File: rtl/sbcg_col_seq.sv
`timescale 1ns/1ps
module sbcg_col_seq
    import sbcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_write,
    input  logic [COL_W-1:0] start_col,
    input  mode_cfg_t        cfg,
    input  logic             terminate,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last,
    output logic             burst_rd,
    output logic             lat3,
    output logic             cfg_err
);
    localparam logic [COL_W-1:0] ONES = {COL_W{1'b1}};

    typedef struct packed {
        logic             active;
        logic             last;
        logic             err;
        logic             rd;
        logic             lat3;
        logic             ilv;
        blen_e            blen;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] addr;
        logic [COL_W-1:0] beat;
    } seq_st_t;

    seq_st_t          st_d, st_q;
    logic [COL_W-1:0] wmask;
    logic [COL_W-1:0] nb;
    blen_e            blen_sel;

    function automatic logic [COL_W-1:0] wrap_of(blen_e b);
        case (b)
            BLEN_1:  return '0;
            BLEN_2:  return COL_W'(1);
            BLEN_4:  return COL_W'(3);
            BLEN_8:  return COL_W'(7);
            default: return ONES;
        endcase
    endfunction

    assign wmask    = wrap_of(st_q.blen);
    assign nb       = st_q.beat + 1'b1;
    assign blen_sel = (is_write && cfg.wr_single) ? BLEN_1 : cfg.blen;

    always_comb begin
        st_d = st_q;
        if (start && !st_q.err) begin
            if (cfg.bad) begin
                st_d.err    = 1'b1;
                st_d.active = 1'b0;
                st_d.last   = 1'b0;
            end else begin
                st_d.active = 1'b1;
                st_d.blen   = blen_sel;
                st_d.ilv    = cfg.ilv;
                st_d.rd     = !is_write;
                st_d.base   = start_col;
                st_d.addr   = start_col;
                st_d.beat   = '0;
                st_d.last   = (blen_sel == BLEN_1);
                if (!is_write) begin
                    st_d.lat3 = cfg.lat3;
                end
            end
        end else if (st_q.active) begin
            if (terminate || st_q.last) begin
                st_d.active = 1'b0;
                st_d.last   = 1'b0;
            end else begin
                st_d.beat = nb;
                if (st_q.blen == BLEN_PAGE) begin
                    st_d.addr = st_q.base + nb;
                end else if (st_q.ilv) begin
                    st_d.addr = st_q.base ^ nb;
                end else begin
                    st_d.addr = (st_q.base & ~wmask) | ((st_q.base + nb) & wmask);
                end
                st_d.last = (st_q.blen != BLEN_PAGE) && (nb == wmask);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col_addr  = st_q.addr;
    assign col_valid = st_q.active;
    assign col_last  = st_q.active && st_q.last;
    assign burst_rd  = st_q.active && st_q.rd;
    assign lat3      = st_q.lat3;
    assign cfg_err   = st_q.err;

    AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        terminate && !start |=> !col_valid); // R6
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active && !st_q.last && !terminate && !start && !st_q.ilv && st_q.blen == BLEN_8
        |=> col_valid && col_addr[2:0] == $past(col_addr[2:0]) + 3'd1
            && col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3])); // R2
    AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid); // R5
    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && st_q.blen == BLEN_PAGE |-> !col_last); // R4
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start && !cfg.bad && !cfg_err |=> col_valid && col_addr == $past(start_col)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R11
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !col_valid); // R11

endmodule

// File: rtl/sbcg_rd_pipe.sv
`timescale 1ns/1ps
module sbcg_rd_pipe #(
    parameter int MAX_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_rd,
    input  logic lat3,
    input  logic rd_mask,
    output logic rd_data_valid,
    output logic dq_oe
);
    localparam int DEPTH = MAX_LAT - 1;
    localparam int MASK_D = 2;

    typedef struct packed {
        logic [DEPTH-1:0]  vpipe;
        logic [MASK_D-1:0] mpipe;
        logic [1:0]        armed;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.vpipe = {st_q.vpipe[DEPTH-2:0], beat_rd};
        st_d.mpipe = {st_q.mpipe[MASK_D-2:0], rd_mask};
        if (st_q.armed != 2'd2) st_d.armed = st_q.armed + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_valid = lat3 ? st_q.vpipe[DEPTH-1] : st_q.vpipe[DEPTH-2];
    assign dq_oe         = rd_data_valid && !st_q.mpipe[MASK_D-1];

    AST_MASK_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed == 2'd2 && $past(rd_mask, 2) |-> !dq_oe); // R10
    AST_OE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed == 2'd2 && !$past(rd_mask, 2) && rd_data_valid |-> dq_oe); // R10

endmodule

// File: rtl/sdram_burst_colgen.sv
`timescale 1ns/1ps
module sdram_burst_colgen
    import sbcg_pkg::*;
#(
    parameter int COL_W   = 8,
    parameter int MODE_W  = 12,
    parameter int MAX_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_write,
    input  logic [COL_W-1:0]  start_col,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              terminate,
    input  logic              rd_mask,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_last,
    output logic              rd_data_valid,
    output logic              dq_oe,
    output logic              config_error
);
    mode_cfg_t cfg;
    logic      burst_rd;
    logic      lat3;

    sbcg_mode_decode #(.MODE_W(MODE_W)) u_dec (
        .mode_word (mode_word),
        .cfg       (cfg)
    );

    sbcg_col_seq #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_write  (is_write),
        .start_col (start_col),
        .cfg       (cfg),
        .terminate (terminate),
        .col_addr  (col_addr),
        .col_valid (col_valid),
        .col_last  (col_last),
        .burst_rd  (burst_rd),
        .lat3      (lat3),
        .cfg_err   (config_error)
    );

    sbcg_rd_pipe #(.MAX_LAT(MAX_LAT)) u_pipe (
        .clk           (clk),
        .rst_n         (rst_n),
        .beat_rd       (burst_rd),
        .lat3          (lat3),
        .rd_mask       (rd_mask),
        .rd_data_valid (rd_data_valid),
        .dq_oe         (dq_oe)
    );

    AST_RDV_CL2: assert property (@(posedge clk) disable iff (!rst_n)
        burst_rd && !lat3 && !start |=> rd_data_valid); // R9
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !burst_rd && !start |=> ##1 !rd_data_valid || lat3); // R9

endmodule

// File: tb/sim_sdram_burst_colgen.sv
`timescale 1ns/1ps
module sim_sdram_burst_colgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_write = 1'b0;
    logic [7:0]  start_col = '0;
    logic [11:0] mode_word = '0;
    logic        terminate = 1'b0;
    logic        rd_mask = 1'b0;
    logic [7:0]  col_addr;
    logic        col_valid, col_last, rd_data_valid, dq_oe, config_error;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sdram_burst_colgen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
        .start_col(start_col), .mode_word(mode_word), .terminate(terminate),
        .rd_mask(rd_mask), .col_addr(col_addr), .col_valid(col_valid),
        .col_last(col_last), .rd_data_valid(rd_data_valid), .dq_oe(dq_oe),
        .config_error(config_error)
    );

    function automatic logic [11:0] mk(logic [2:0] bl, logic bt, logic [2:0] cl, logic wm);
        return {2'b00, wm, 2'b00, cl, bt, bl};
    endfunction

    function automatic logic [7:0] exp_col(logic [7:0] c, int i, int m, bit full, bit ilv);
        if (full) return c + 8'(i);
        if (ilv)  return c ^ 8'(i);
        return (c & ~8'(m)) | ((c + 8'(i)) & 8'(m));
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; terminate = 1'b0; rd_mask = 1'b0;
        repeat (3) cyc();
        chk(!col_valid && !col_last && !rd_data_valid && !dq_oe && !config_error,
            "R12", "outputs in reset", int'(col_valid | col_last | rd_data_valid | dq_oe | config_error), 0);
        rst_n = 1'b1;
        cyc();
        chk(!col_valid && !config_error, "R12", "outputs after reset", int'(col_valid | config_error), 0);
    endtask

    task automatic run_burst(string req, logic [11:0] mode, logic [7:0] col, bit wr,
                             int nbeats, int m, bit full, bit ilv, bit term);
        start = 1'b1; is_write = wr; start_col = col; mode_word = mode;
        cyc();
        start = 1'b0;
        for (int i = 0; i < nbeats; i++) begin
            logic [7:0] e;
            bit el;
            e  = exp_col(col, i, m, full, ilv);
            el = !full && (i == m);
            chk(col_valid === 1'b1, req, "col_valid", int'(col_valid), 1);
            chk(col_addr === e, req, "col_addr", int'(col_addr), int'(e));
            chk(col_last === el, req, "col_last", int'(col_last), int'(el));
            if (term && i == nbeats - 1) terminate = 1'b1;
            cyc();
            terminate = 1'b0;
        end
        chk(col_valid === 1'b0, req, "col_valid after burst", int'(col_valid), 0);
        repeat (4) cyc();
    endtask

    task automatic rd_timing(string req, logic [2:0] cl, bit wr, int mask_cyc);
        int lat;
        lat = (cl == 3'b011) ? 3 : 2;
        start = 1'b1; is_write = wr; start_col = 8'h40; mode_word = mk(3'b010, 1'b0, cl, 1'b0);
        rd_mask = (mask_cyc == 0);
        cyc();
        start = 1'b0;
        for (int j = 1; j <= 8; j++) begin
            bit ev, eo;
            rd_mask = (mask_cyc == j);
            ev = !wr && (j >= lat) && (j < lat + 4);
            eo = ev && (j != mask_cyc + 2);
            chk(rd_data_valid === ev, req, "rd_data_valid", int'(rd_data_valid), int'(ev));
            chk(dq_oe === eo, req, "dq_oe", int'(dq_oe), int'(eo));
            cyc();
        end
        rd_mask = 1'b0;
        repeat (3) cyc();
    endtask

    task automatic restart_test();
        start = 1'b1; is_write = 1'b0; start_col = 8'h10; mode_word = mk(3'b011, 1'b0, 3'b010, 1'b0);
        cyc();
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(col_addr === 8'(8'h10 + i) && col_valid, "R7", "first burst addr", int'(col_addr), 16 + i);
            if (i == 2) begin
                start = 1'b1; start_col = 8'h86; mode_word = mk(3'b010, 1'b0, 3'b010, 1'b0);
            end
            cyc();
        end
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] e;
            e = exp_col(8'h86, i, 3, 1'b0, 1'b0);
            chk(col_valid && col_addr === e, "R7", "second burst addr", int'(col_addr), int'(e));
            chk(col_last === (i == 3), "R7", "second burst last", int'(col_last), int'(i == 3));
            cyc();
        end
        chk(col_valid === 1'b0, "R7", "idle after restart", int'(col_valid), 0);
        repeat (4) cyc();
    endtask

    task automatic err_test(string what, logic [11:0] mode);
        start = 1'b1; is_write = 1'b0; start_col = 8'h00; mode_word = mode;
        cyc();
        start = 1'b0;
        chk(config_error === 1'b1, "R11", {what, " error set"}, int'(config_error), 1);
        chk(col_valid === 1'b0, "R11", {what, " no beat"}, int'(col_valid), 0);
        start = 1'b1; mode_word = mk(3'b010, 1'b0, 3'b010, 1'b0);
        cyc();
        start = 1'b0;
        chk(col_valid === 1'b0, "R11", {what, " good start blocked"}, int'(col_valid), 0);
        repeat (3) cyc();
        chk(config_error === 1'b1 && !rd_data_valid, "R11", {what, " error sticky"}, int'(config_error), 1);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R1 R2 R5: sequential BL8 from 0x2D
        run_burst("R2", mk(3'b011, 1'b0, 3'b010, 1'b0), 8'h2D, 1'b0, 8, 7, 1'b0, 1'b0, 1'b0);
        // R3: interleaved BL8 from 0x2D
        run_burst("R3", mk(3'b011, 1'b1, 3'b010, 1'b0), 8'h2D, 1'b0, 8, 7, 1'b0, 1'b1, 1'b0);
        // R1: BL4 sequential, BL2 interleaved, BL1
        run_burst("R1", mk(3'b010, 1'b0, 3'b011, 1'b0), 8'h12, 1'b0, 4, 3, 1'b0, 1'b0, 1'b0);
        run_burst("R1", mk(3'b001, 1'b1, 3'b010, 1'b0), 8'h07, 1'b1, 2, 1, 1'b0, 1'b1, 1'b0);
        run_burst("R5", mk(3'b000, 1'b0, 3'b010, 1'b0), 8'hA3, 1'b0, 1, 0, 1'b0, 1'b0, 1'b0);
        // R4 R6: full page rollover ended by terminate
        run_burst("R4", mk(3'b111, 1'b0, 3'b010, 1'b0), 8'hFD, 1'b0, 6, 255, 1'b1, 1'b0, 1'b1);
        // R6: terminate mid BL8
        run_burst("R6", mk(3'b011, 1'b0, 3'b010, 1'b0), 8'h30, 1'b1, 3, 7, 1'b0, 1'b0, 1'b1);
        restart_test();
        // R8: single-location write, read keeps BL8
        run_burst("R8", mk(3'b011, 1'b0, 3'b010, 1'b1), 8'h09, 1'b1, 1, 0, 1'b0, 1'b0, 1'b0);
        run_burst("R8", mk(3'b011, 1'b0, 3'b010, 1'b1), 8'h09, 1'b0, 8, 7, 1'b0, 1'b0, 1'b0);
        // R9: latency 2 and 3, write silent
        rd_timing("R9", 3'b010, 1'b0, -10);
        rd_timing("R9", 3'b011, 1'b0, -10);
        rd_timing("R9", 3'b011, 1'b1, -10);
        // R10: mask in cycle 2 removes enable in cycle 4
        rd_timing("R10", 3'b011, 1'b0, 2);
        rd_timing("R10", 3'b010, 1'b0, 3);
        // R11: reserved burst length, then reserved latency
        err_test("bl", mk(3'b100, 1'b0, 3'b010, 1'b0));
        do_reset();
        err_test("cl", mk(3'b010, 1'b0, 3'b001, 1'b0));
        do_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule